// File: doc/BRIEF.md
# Quadlet-Assembling Host Bus Slave

This block is a microprocessor bus slave. It gives a narrow host bus access to a small file of 32-bit quadlet registers. The host moves data either one byte at a time or one 16-bit halfword at a time. The low address bits may arrive on their own bus, or they may share the low data lane and be captured by an address latch strobe. Reads and writes are framed by an active-low chip select. The block accepts either separate read and write strobes or a single read/write line: that line is tied to the write strobe, and the read strobe is held low.

A ninth address bit turns a group of narrow transfers into one atomic quadlet operation. Write transfers merge their bytes into a write holding register. The write that carries the ninth bit stores the merged quadlet into the addressed register in a single step. A read that carries the ninth bit takes a snapshot of the whole register into a read holding register. Later reads without the ninth bit return lanes of that snapshot. Each such fetch or store holds the wait output high for one clock cycle.

One quadlet of the file holds interrupt-pending flags. Pulses on the interrupt source inputs set these flags. Storing ones to that quadlet clears the matching flags. While any flag is set, the block enables a pull-down on its open-drain interrupt line.

Top module: `quad_hif`

## Requirements
- R1: After the asynchronous active-low reset, the wait output, the interrupt pull-down and both data output enables are low. Every register, both holding registers and all pending flags read as zero.
- R2: In 8-bit mode (bus16_i low), a write places ad_i in byte lane addr[1:0] of the write holding register. Lane 0 is bits 7:0. The register file does not change until a write with the ninth bit (a8_i) high stores the merged quadlet into quadlet index addr[7:2].
- R3: In 16-bit mode (bus16_i high), a transfer covers halfword addr[1]. ad_i and ad_o carry the lower byte of the halfword, and d_hi_i and d_hi_o carry the upper byte.
- R4: In multiplexed mode (mux_i high), the byte address is the value on ad_i captured while ale_i is high, and addr_i is ignored. In direct mode the byte address is taken from addr_i.
- R5: A read with a8_i high copies the whole addressed quadlet into the read holding register. Reads with a8_i low return lanes of that copy, even if the register has been written since the copy was taken.
- R6: With chip select active, write strobe low means a write whatever the read strobe is. The data outputs are never enabled while the write strobe is low.
- R7: While cs_ni is high, no transfer takes place: no register changes, wait stays low and the data outputs stay disabled.
- R8: wait_o is high for exactly one clock cycle after an access whose a8_i is high, and only after such an access. A transfer with a8_i low never raises wait_o.
- R9: A high bit of irq_set_i sets the pending flag with the same index. Quadlet index 3 (byte address 0x0C) reads the flags in bits 7:0. Storing a quadlet there clears every flag whose bit is 1. int_oe_o is high while any flag is set.
- R10: Quadlet indices at or above 4 read as zero, and stores to them have no effect.
- R11: ad_oe_o is high only while a read strobe is active after the access has started. d_hi_oe_o is high only when ad_oe_o is high and bus16_i is high.

Port widths below use the default parameters (IRQ_W = 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus16_i | input | 1 | Width mode: 0 byte transfers, 1 halfword transfers |
| mux_i | input | 1 | Address mode: 1 address on ad_i latched by ale_i, 0 address on addr_i |
| ale_i | input | 1 | Address latch strobe for multiplexed mode |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low (dominates rd_ni) |
| rd_ni | input | 1 | Read strobe, active low |
| addr_i | input | 8 | Byte address in direct mode |
| a8_i | input | 1 | Quadlet mark: first read / last write |
| ad_i | input | 8 | Low data lane in; multiplexed address |
| d_hi_i | input | 8 | High data lane in, 16-bit mode |
| ad_o | output | 8 | Low data lane out |
| d_hi_o | output | 8 | High data lane out |
| ad_oe_o | output | 1 | Output enable for the low lane |
| d_hi_oe_o | output | 1 | Output enable for the high lane |
| wait_o | output | 1 | High while a quadlet fetch or store completes |
| int_oe_o | output | 1 | Pull-down enable for the open-drain interrupt line |
| irq_set_i | input | 8 | Interrupt source pulses, one per pending flag |

## Verification
The assertions check four things on every cycle. The wait pulse lasts one cycle and is caused only by a marked, selected access. The output drivers stay off while the chip is deselected or the write strobe is low. The high lane driver is enabled only in 16-bit mode during a read. The interrupt line can only start being pulled low after a source pulse. The bench scenarios cover what needs a sequence of transfers and knowledge of stored values. These are lane placement in both widths, multiplexed address capture with a conflicting direct address, commit-only-on-mark, the snapshot surviving a later store, write dominance on a combined strobe, out-of-range quadlets, and write-one-to-clear of pending flags.

// File: rtl/quad_hif_pkg.sv
package quad_hif_pkg;
  localparam int QW = 32;
  localparam int AW = 8;

  typedef struct packed {
    logic          wr;
    logic          a8;
    logic [AW-1:0] addr;
  } acc_t;
endpackage

// File: rtl/quad_hif_decode.sv
module quad_hif_decode
  import quad_hif_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mux_i,
  input  logic          ale_i,
  input  logic          cs_ni,
  input  logic          wr_ni,
  input  logic          rd_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          a8_i,
  input  logic [7:0]    ad_i,
  output logic          ev_o,
  output acc_t          acc_o,
  output logic [AW-1:0] cur_addr_o,
  output logic          rd_drive_o
);
  logic          strobe, strobe_q, is_wr;
  logic [AW-1:0] ale_addr_q;
  logic          rd_act_q;

  // write strobe wins when both are low
  assign is_wr  = ~wr_ni;
  assign strobe = ~cs_ni & (~wr_ni | ~rd_ni);
  assign ev_o   = strobe & ~strobe_q;

  assign acc_o.wr   = is_wr;
  assign acc_o.a8   = a8_i;
  assign acc_o.addr = mux_i ? ale_addr_q : addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q   <= 1'b0;
      ale_addr_q <= '0;
      rd_act_q   <= 1'b0;
      cur_addr_o <= '0;
    end else begin
      strobe_q <= strobe;
      if (ale_i) ale_addr_q <= ad_i;
      if (ev_o) cur_addr_o <= acc_o.addr;
      if (!strobe)              rd_act_q <= 1'b0;
      else if (ev_o && !is_wr)  rd_act_q <= 1'b1;
    end
  end

  assign rd_drive_o = rd_act_q & strobe & ~is_wr;
endmodule

// File: rtl/quad_hif_lanes.sv
module quad_hif_lanes
  import quad_hif_pkg::*;
(
  input  logic          bus16_i,
  input  logic [QW-1:0] wr_hold_i,
  input  logic [15:0]   wr_data_i,
  input  logic [1:0]    wr_lane_i,
  output logic [QW-1:0] merged_o,
  input  logic [QW-1:0] rd_hold_i,
  input  logic [1:0]    rd_lane_i,
  output logic [7:0]    rd_lo_o,
  output logic [7:0]    rd_hi_o
);
  always_comb begin
    merged_o = wr_hold_i;
    if (bus16_i) merged_o[{wr_lane_i[1], 4'b0000} +: 16] = wr_data_i;
    else         merged_o[{wr_lane_i, 3'b000} +: 8]      = wr_data_i[7:0];
  end

  logic lo_sel;
  assign lo_sel  = bus16_i ? 1'b0 : rd_lane_i[0];
  assign rd_lo_o = rd_hold_i[{rd_lane_i[1], lo_sel, 3'b000} +: 8];
  assign rd_hi_o = bus16_i ? rd_hold_i[{rd_lane_i[1], 1'b1, 3'b000} +: 8] : 8'h00;
endmodule

// File: rtl/quad_hif_regs.sv
module quad_hif_regs
  import quad_hif_pkg::*;
#(
  parameter int NREG    = 4,
  parameter int IRQ_IDX = 3,
  parameter int IRQ_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-3:0]     widx_i,
  input  logic [QW-1:0]     wdata_i,
  input  logic [AW-3:0]     ridx_i,
  output logic [QW-1:0]     rdata_o,
  input  logic [IRQ_W-1:0]  irq_set_i,
  output logic [IRQ_W-1:0]  pend_o
);
  localparam int IDXW = AW - 2;

  logic [QW-1:0] rd_vec [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit;
    assign hit = we_i && (widx_i == IDXW'(i));
    if (i == IRQ_IDX) begin : g_irq
      logic [IRQ_W-1:0] pend_q;
      logic [IRQ_W-1:0] clr;
      assign clr = hit ? wdata_i[IRQ_W-1:0] : '0;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= (pend_q & ~clr) | irq_set_i;
      end
      assign rd_vec[i] = {{(QW-IRQ_W){1'b0}}, pend_q};
      assign pend_o    = pend_q;
    end else begin : g_plain
      logic [QW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= '0;
        else if (hit) q <= wdata_i;
      end
      assign rd_vec[i] = q;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++)
      if (ridx_i == IDXW'(i)) rdata_o = rd_vec[i];
  end
endmodule

// File: rtl/quad_hif.sv
module quad_hif
  import quad_hif_pkg::*;
#(
  parameter int NREG    = 4,
  parameter int IRQ_IDX = 3,
  parameter int IRQ_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus16_i,
  input  logic             mux_i,
  input  logic             ale_i,
  input  logic             cs_ni,
  input  logic             wr_ni,
  input  logic             rd_ni,
  input  logic [7:0]       addr_i,
  input  logic             a8_i,
  input  logic [7:0]       ad_i,
  input  logic [7:0]       d_hi_i,
  output logic [7:0]       ad_o,
  output logic [7:0]       d_hi_o,
  output logic             ad_oe_o,
  output logic             d_hi_oe_o,
  output logic             wait_o,
  output logic             int_oe_o,
  input  logic [IRQ_W-1:0] irq_set_i
);
  logic          ev, rd_drive;
  acc_t          acc;
  logic [AW-1:0] cur_addr;
  logic [QW-1:0] wr_hold_q, rd_hold_q, merged, rdata;
  logic [IRQ_W-1:0] pend;
  logic          wait_q, commit, fetch;

  quad_hif_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mux_i      (mux_i),
    .ale_i      (ale_i),
    .cs_ni      (cs_ni),
    .wr_ni      (wr_ni),
    .rd_ni      (rd_ni),
    .addr_i     (addr_i),
    .a8_i       (a8_i),
    .ad_i       (ad_i),
    .ev_o       (ev),
    .acc_o      (acc),
    .cur_addr_o (cur_addr),
    .rd_drive_o (rd_drive)
  );

  quad_hif_lanes u_lanes (
    .bus16_i   (bus16_i),
    .wr_hold_i (wr_hold_q),
    .wr_data_i ({d_hi_i, ad_i}),
    .wr_lane_i (acc.addr[1:0]),
    .merged_o  (merged),
    .rd_hold_i (rd_hold_q),
    .rd_lane_i (cur_addr[1:0]),
    .rd_lo_o   (ad_o),
    .rd_hi_o   (d_hi_o)
  );

  assign commit = ev & acc.wr & acc.a8;
  assign fetch  = ev & ~acc.wr & acc.a8;

  quad_hif_regs #(
    .NREG    (NREG),
    .IRQ_IDX (IRQ_IDX),
    .IRQ_W   (IRQ_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (commit),
    .widx_i    (acc.addr[AW-1:2]),
    .wdata_i   (merged),
    .ridx_i    (acc.addr[AW-1:2]),
    .rdata_o   (rdata),
    .irq_set_i (irq_set_i),
    .pend_o    (pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_hold_q <= '0;
      rd_hold_q <= '0;
      wait_q    <= 1'b0;
    end else begin
      wait_q <= ev & acc.a8;
      if (ev && acc.wr) wr_hold_q <= merged;
      if (fetch)        rd_hold_q <= rdata;
    end
  end

  assign wait_o    = wait_q;
  assign ad_oe_o   = rd_drive;
  assign d_hi_oe_o = rd_drive & bus16_i;
  assign int_oe_o  = |pend;
endmodule

// File: rtl/quad_hif_chk.sv
module quad_hif_chk #(
  parameter int IRQ_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus16_i,
  input logic             cs_ni,
  input logic             wr_ni,
  input logic             rd_ni,
  input logic             a8_i,
  input logic             ad_oe_o,
  input logic             d_hi_oe_o,
  input logic             wait_o,
  input logic             int_oe_o,
  input logic [IRQ_W-1:0] irq_set_i
);
  AST_WAIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |=> !wait_o); // R8
  AST_WAIT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> $past(!cs_ni && (!wr_ni || !rd_ni) && a8_i)); // R8
  AST_NO_DRIVE_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !ad_oe_o); // R7
  AST_NO_DRIVE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ni |-> !ad_oe_o); // R6
  AST_HI_LANE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_hi_oe_o |-> (bus16_i && ad_oe_o)); // R11
  AST_INT_FROM_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_oe_o) |-> $past(|irq_set_i)); // R9
endmodule

bind quad_hif quad_hif_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus16_i   (bus16_i),
  .cs_ni     (cs_ni),
  .wr_ni     (wr_ni),
  .rd_ni     (rd_ni),
  .a8_i      (a8_i),
  .ad_oe_o   (ad_oe_o),
  .d_hi_oe_o (d_hi_oe_o),
  .wait_o    (wait_o),
  .int_oe_o  (int_oe_o),
  .irq_set_i (irq_set_i)
);

// File: tb/quad_hif_tb_top.sv
module quad_hif_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus16 = 1'b0, mux = 1'b0, ale = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, a8 = 1'b0;
  logic [7:0] addr = '0, ad_in = '0, dhi_in = '0, irq_set = '0;
  logic [7:0] ad_out, dhi_out;
  logic ad_oe, dhi_oe, wait_s, int_oe;

  always #4 clk = ~clk;  // 125 MHz

  quad_hif dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus16_i(bus16), .mux_i(mux), .ale_i(ale),
    .cs_ni(cs_n), .wr_ni(wr_n), .rd_ni(rd_n), .addr_i(addr), .a8_i(a8),
    .ad_i(ad_in), .d_hi_i(dhi_in), .ad_o(ad_out), .d_hi_o(dhi_out),
    .ad_oe_o(ad_oe), .d_hi_oe_o(dhi_oe), .wait_o(wait_s), .int_oe_o(int_oe),
    .irq_set_i(irq_set)
  );

  // observation word: {wait, int, ad_oe, hi_oe, d_hi, ad}
  localparam logic [19:0] M_WAIT = 20'h80000;
  localparam logic [19:0] M_INT  = 20'h40000;
  localparam logic [19:0] M_OE   = 20'h30000;
  localparam logic [19:0] M_ALL  = 20'hFFFFF;

  typedef struct { int req; logic [19:0] mask; logic [19:0] exp; } item_t;
  item_t sb_q[$];
  int n_vec = 0, n_fail = 0;
  logic [19:0] obs;
  assign obs = {wait_s, int_oe, ad_oe, dhi_oe, dhi_out, ad_out};

  // monitor: items pushed just after a rising edge are compared at the next falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_vec++;
      if ((obs & it.mask) != (it.exp & it.mask)) begin
        n_fail++;
        $display("FAIL R%0d: got %05h expected %05h (mask %05h)",
                 it.req, obs & it.mask, it.exp & it.mask, it.mask);
      end
    end
  end

  task automatic expect_obs(input int req, input logic [19:0] m, input logic [19:0] e);
    item_t it;
    it.req = req; it.mask = m; it.exp = e;
    sb_q.push_back(it);
  endtask

  task automatic latch_addr(input logic [7:0] a);
    if (mux) begin
      @(posedge clk); #2 ale = 1'b1; ad_in = a;
      @(posedge clk); #2 ale = 1'b0;
    end
  endtask

  task automatic bus_wr(input int req, input logic [7:0] a, input logic mark,
                        input logic [15:0] d, input logic sel, input logic both);
    latch_addr(a);
    @(posedge clk); #2;
    cs_n = ~sel; wr_n = 1'b0; rd_n = ~both; a8 = mark;
    addr = mux ? ~a : a; ad_in = d[7:0]; dhi_in = d[15:8];
    @(posedge clk); #2;
    expect_obs(req, M_WAIT | M_OE, {mark & sel, 19'h0});
    @(posedge clk); #2;
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; a8 = 1'b0;
    expect_obs(req, M_WAIT | M_OE, 20'h0);
  endtask

  task automatic bus_rd(input int req, input logic [7:0] a, input logic mark,
                        input logic [15:0] e);
    logic [19:0] m;
    latch_addr(a);
    @(posedge clk); #2;
    cs_n = 1'b0; rd_n = 1'b0; a8 = mark; addr = mux ? ~a : a;
    @(posedge clk); #2;
    m = M_WAIT | M_OE | 20'h000FF | (bus16 ? 20'h0FF00 : 20'h0);
    expect_obs(req, m, {mark, 1'b0, 1'b1, bus16, bus16 ? e[15:8] : 8'h00, e[7:0]});
    @(posedge clk); #2;
    cs_n = 1'b1; rd_n = 1'b1; a8 = 1'b0;
    expect_obs(req, M_WAIT | M_OE, 20'h0);
  endtask

  task automatic wr_quad8(input int req, input logic [7:0] base, input logic [31:0] q);
    for (int b = 0; b < 4; b++)
      bus_wr(req, base + 8'(b), b == 3, {8'h00, q[b*8 +: 8]}, 1'b1, 1'b0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    // R1: idle outputs after reset, zero contents
    expect_obs(1, M_WAIT | M_INT | M_OE, 20'h0);
    bus_rd(1, 8'h00, 1'b1, 16'h0000);

    // R2: partial byte writes are not visible before the marked last write
    bus_wr(2, 8'h04, 1'b0, 16'h0011, 1'b1, 1'b0);
    bus_wr(2, 8'h05, 1'b0, 16'h0022, 1'b1, 1'b0);
    bus_wr(2, 8'h06, 1'b0, 16'h0033, 1'b1, 1'b0);
    bus_rd(2, 8'h04, 1'b1, 16'h0000);
    bus_wr(2, 8'h07, 1'b1, 16'h0044, 1'b1, 1'b0);
    bus_rd(2, 8'h04, 1'b1, 16'h0011);
    bus_rd(2, 8'h05, 1'b0, 16'h0022);
    bus_rd(8, 8'h07, 1'b0, 16'h0044);  // R8: no wait on unmarked read

    // R5: snapshot survives a later store
    bus_rd(5, 8'h04, 1'b1, 16'h0011);
    wr_quad8(5, 8'h04, 32'hAAAA_AAAA);
    bus_rd(5, 8'h06, 1'b0, 16'h0033);
    bus_rd(5, 8'h06, 1'b1, 16'h00AA);

    // R3, R11: halfword transfers with the upper lane
    bus16 = 1'b1;
    bus_wr(3, 8'h08, 1'b0, 16'hBEEF, 1'b1, 1'b0);
    bus_wr(3, 8'h0A, 1'b1, 16'hCAFE, 1'b1, 1'b0);
    bus_rd(3, 8'h08, 1'b1, 16'hBEEF);
    bus_rd(11, 8'h0A, 1'b0, 16'hCAFE);
    bus16 = 1'b0;

    // R4: multiplexed address, conflicting direct address ignored
    mux = 1'b1;
    wr_quad8(4, 8'h00, 32'h0403_0201);
    bus_rd(4, 8'h02, 1'b1, 16'h0003);
    bus_rd(4, 8'h01, 1'b0, 16'h0002);
    mux = 1'b0;

    // R6: both strobes low is a write, outputs stay off
    bus_wr(6, 8'h03, 1'b1, 16'h0099, 1'b1, 1'b1);
    bus_rd(6, 8'h03, 1'b1, 16'h0099);

    // R7: deselected write has no effect
    bus_wr(7, 8'h03, 1'b1, 16'h0077, 1'b0, 1'b0);
    bus_rd(7, 8'h03, 1'b1, 16'h0099);

    // R10: out-of-range quadlet
    wr_quad8(10, 8'h14, 32'h1234_5678);
    bus_rd(10, 8'h14, 1'b1, 16'h0000);

    // R9: pending flags, read and write-one-to-clear
    @(posedge clk); #2 irq_set = 8'h05;
    @(posedge clk); #2 irq_set = 8'h00;
    expect_obs(9, M_INT, M_INT);
    bus_rd(9, 8'h0C, 1'b1, 16'h0005);
    wr_quad8(9, 8'h0C, 32'h0000_0001);
    expect_obs(9, M_INT, M_INT);
    bus_rd(9, 8'h0C, 1'b1, 16'h0004);
    wr_quad8(9, 8'h0C, 32'h0000_0004);
    expect_obs(9, M_INT, 20'h0);
    bus_rd(9, 8'h0C, 1'b1, 16'h0000);

    // R1: asynchronous reset clears stored quadlets
    @(posedge clk); #2 rst_n = 1'b0;
    @(posedge clk); #2 rst_n = 1'b1;
    bus_rd(1, 8'h08, 1'b1, 16'h0000);

    repeat (2) @(posedge clk);
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule